// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block is the central arbiter of a shared parallel bus. Each master drives an active-low request line, and the arbiter drives one active-low grant line back to each master. The masters are split into a high group (the lowest indices) and a low group (the remaining indices). Under full load the high group takes one complete rotation, and then a single low-group master gets one turn. The low group keeps its own rotation, so its members take those single turns in order. A build parameter replaces both rotations with fixed priority, where the lowest index wins.

The arbiter watches the bus idle condition, which is `frame_n` and `irdy_n` both high. A transaction starts when the bus was idle in one cycle and `frame_n` is low in the next. That start is charged to the master holding the grant, and the rotation then moves past that master. Arbitration is hidden. The grant can move to the next winner while the current owner is still transferring. Taking the grant away from a busy owner asks it to give up the bus, and it stops once its own ownership timer allows. When nobody requests, the grant is parked. A build parameter chooses whether it parks on a fixed default master or on the master that last started a transaction.

Top module: `tier_arbiter`

## Requirements
- R1: While `rst` is sampled high, all grants are high in the following cycle. After the first clock edge with `rst` low and no requests, exactly the grant of master `PARK_ID` is low.
- R2: At most one bit of `gnt_n` is low in any cycle.
- R3: The grant never moves directly from one master to another. Between two different granted masters there is at least one cycle with all grants high.
- R4: With the rotating build and every master requesting, transaction starts follow slot sequence k = 0, 1, 2 and so on. Slot position s = k mod (N_HI+1). For s < N_HI the master is index s. For s = N_HI the master is index N_HI + ((k div (N_HI+1)) mod N_LO). With two high and three low masters this gives 0,1,2,0,1,3,0,1,4 and then repeats.
- R5: With the fixed-priority build (`FIXED_PRIO`=1), a requesting master 0 wins every arbitration. Under full load every transaction is started by master 0.
- R6: With `PARK_LAST`=0, once no master has requested for one cycle, any asserted grant belongs to master `PARK_ID`.
- R7: With `PARK_LAST`=1, when requests stop, the grant settles on the master that started the most recent transaction.
- R8: While one master's transaction is in progress (`frame_n` or `irdy_n` low), the grant can be removed from that owner and given to the next winner.
- R9: A granted master that raises its request before it starts a transaction forfeits its turn. The rotation moves past it even if it requests again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | N_HI+N_LO | Active-low requests, high group at the low indices |
| frame_n | input | 1 | Bus frame signal, active low |
| irdy_n | input | 1 | Bus initiator-ready signal, active low |
| gnt_n | output | N_HI+N_LO | Registered active-low grants |

## Verification
The assertions check on every cycle that at most one grant is low, that a grant change always passes through an all-high cycle, and that reset clears the grants. In the default-park build they also check that no grant other than the default survives a cycle with no request. In the fixed-priority build they check that master 0 wins any fresh grant it requests.

The nested rotation order, the forfeited turn of a master that drops its request, parking on the last owner, and grant handover during a running transaction all depend on a sequence of transactions. Only the bench scenarios can show these. The bench drives a simple bus model for each master and compares the recorded order of transaction starts against the slot formula.

// File: rtl/tier_arb_pkg.sv
package tier_arb_pkg;
  // Next position in a ring of w entries.
  function automatic int wrap_next(input int v, input int w);
    return (v + 1 >= w) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/tier_rr_pick.sv
module tier_rr_pick #(
  parameter int W     = 3,
  parameter int PW    = 2,
  parameter int FIXED = 0
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          any,
  output logic [PW-1:0] idx
);
  int base;

  generate
    if (FIXED != 0) begin : g_fixed
      assign base = 0;
    end else begin : g_rot
      assign base = int'(ptr);
    end
  endgenerate

  always_comb begin
    int s;
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < W; k++) begin
      s = base + k;
      if (s >= W) s = s - W;
      if (!any && req[s]) begin
        any = 1'b1;
        idx = PW'(s);
      end
    end
  end
endmodule

// File: rtl/tier_bus_watch.sv
module tier_bus_watch (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  output logic start
);
  logic idle_q;

  always_ff @(posedge clk) begin
    if (rst) idle_q <= 1'b1;
    else     idle_q <= frame_n & irdy_n;
  end

  // Bus was idle last cycle and a frame has just begun.
  assign start = idle_q & ~frame_n;
endmodule

// File: rtl/tier_grant_hold.sv
module tier_grant_hold #(
  parameter int NM = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] target,
  output logic          gvalid,
  output logic [IW-1:0] gidx,
  output logic [NM-1:0] gnt_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gvalid <= 1'b0;
      gidx   <= '0;
      gnt_n  <= '1;
    end else if (!gvalid) begin
      gvalid <= 1'b1;
      gidx   <= target;
      gnt_n  <= ~(NM'(1) << target);
    end else if (gidx != target) begin
      // Withdraw first; the new winner is granted next cycle.
      gvalid <= 1'b0;
      gnt_n  <= '1;
    end
  end
endmodule

// File: rtl/tier_arbiter.sv
module tier_arbiter
  import tier_arb_pkg::*;
#(
  parameter int N_HI       = 2,
  parameter int N_LO       = 3,
  parameter int FIXED_PRIO = 0,
  parameter int PARK_LAST  = 0,
  parameter int PARK_ID    = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_HI+N_LO-1:0] req_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  output logic [N_HI+N_LO-1:0] gnt_n
);
  localparam int NM = N_HI + N_LO;
  localparam int NS = N_HI + 1;
  localparam int IW = $clog2(NM);
  localparam int SW = $clog2(NS);
  localparam int LW = (N_LO > 1) ? $clog2(N_LO) : 1;

  logic [NM-1:0] req, req_q;
  logic [NS-1:0] slot_req;
  logic [SW-1:0] tp, top_idx;
  logic [LW-1:0] lp, low_idx;
  logic          top_any, low_any;
  logic [IW-1:0] winner, target, last_q, gidx;
  logic          gvalid, start, drop, consume;

  assign req      = ~req_n;
  // The low group acts as one extra slot at the end of the high rotation.
  assign slot_req = {|req[NM-1:N_HI], req[N_HI-1:0]};

  tier_rr_pick #(.W(NS), .PW(SW), .FIXED(FIXED_PRIO)) u_top (
    .req(slot_req), .ptr(tp), .any(top_any), .idx(top_idx)
  );

  tier_rr_pick #(.W(N_LO), .PW(LW), .FIXED(FIXED_PRIO)) u_low (
    .req(req[NM-1:N_HI]), .ptr(lp), .any(low_any), .idx(low_idx)
  );

  always_comb begin
    if (int'(top_idx) == N_HI) winner = IW'(N_HI + int'(low_idx));
    else                       winner = IW'(top_idx);
    if (top_any && (int'(top_idx) != N_HI || low_any)) target = winner;
    else if (PARK_LAST != 0)                           target = last_q;
    else                                               target = IW'(PARK_ID);
  end

  tier_bus_watch u_watch (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .start(start)
  );

  tier_grant_hold #(.NM(NM), .IW(IW)) u_hold (
    .clk(clk), .rst(rst), .target(target),
    .gvalid(gvalid), .gidx(gidx), .gnt_n(gnt_n)
  );

  // A turn is used by starting a transaction or by withdrawing the request.
  assign drop    = req_q[gidx] & ~req[gidx];
  assign consume = gvalid & (start | drop);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      tp     <= '0;
      lp     <= '0;
      last_q <= IW'(PARK_ID);
    end else begin
      req_q <= req;
      if (gvalid && start) last_q <= gidx;
      if (consume && FIXED_PRIO == 0) begin
        if (int'(gidx) < N_HI) begin
          tp <= SW'(int'(gidx) + 1);
        end else begin
          tp <= '0;
          lp <= LW'(wrap_next(int'(gidx) - N_HI, N_LO));
        end
      end
    end
  end
endmodule

// File: rtl/tier_arbiter_chk.sv
module tier_arbiter_chk #(
  parameter int N_HI       = 2,
  parameter int N_LO       = 3,
  parameter int FIXED_PRIO = 0,
  parameter int PARK_LAST  = 0,
  parameter int PARK_ID    = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_HI+N_LO-1:0] req_n,
  input logic [N_HI+N_LO-1:0] gnt_n
);
  localparam int NM = N_HI + N_LO;

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (&gnt_n));

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~gnt_n));

  assert_dead_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    !(&gnt_n) |=> ((gnt_n == $past(gnt_n)) || (&gnt_n)));

  generate
    if (PARK_LAST == 0) begin : g_park_chk
      assert_park_default_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(&req_n) && !(&gnt_n)) |-> (gnt_n == ~(NM'(1) << PARK_ID)));
    end
    if (FIXED_PRIO != 0) begin : g_fixed_chk
      assert_fixed_first_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(&gnt_n) && $past(!req_n[0])) |-> !gnt_n[0]);
    end
  endgenerate
endmodule

bind tier_arbiter tier_arbiter_chk #(
  .N_HI(N_HI), .N_LO(N_LO), .FIXED_PRIO(FIXED_PRIO),
  .PARK_LAST(PARK_LAST), .PARK_ID(PARK_ID)
) u_chk (
  .clk(clk), .rst(rst), .req_n(req_n), .gnt_n(gnt_n)
);

// File: tb/tier_arbiter_bench.sv
module tier_arbiter_bench;
  localparam int NH = 2;
  localparam int NL = 3;
  localparam int NM = NH + NL;
  localparam logic [NM-1:0] NONE = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NM-1:0] req_n = '1;
  logic [NM-1:0] req_v = '1;
  logic [1:0] frame_n = 2'b11;
  logic [1:0] irdy_n  = 2'b11;
  logic [NM-1:0] gnt_v [2];

  int nvec = 0, nfail = 0;
  int busy [2];
  int owner [2];
  int log_n [2];
  int log_m [2][64];
  int blen = 4;
  bit hidden_seen = 1'b0;
  bit done = 1'b0;
  logic [NM-1:0] prev_g [2];

  always #2 clk = ~clk;

  // Rotating build, parks on master 0.
  tier_arbiter #(.N_HI(NH), .N_LO(NL)) u_tier_arbiter (
    .clk(clk), .rst(rst), .req_n(req_n), .frame_n(frame_n[0]),
    .irdy_n(irdy_n[0]), .gnt_n(gnt_v[0])
  );

  // Fixed-priority build, parks on the last owner.
  tier_arbiter #(.N_HI(NH), .N_LO(NL), .FIXED_PRIO(1), .PARK_LAST(1)) u_tier_arbiter_fx (
    .clk(clk), .rst(rst), .req_n(req_n), .frame_n(frame_n[1]),
    .irdy_n(irdy_n[1]), .gnt_n(gnt_v[1])
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_bit(input logic [NM-1:0] g);
    for (int i = 0; i < NM; i++) if (!g[i]) return i;
    return -1;
  endfunction

  // One cycle: apply requests, check grant shape, run each bus model.
  task automatic step();
    int g;
    @(negedge clk);
    req_n = req_v;
    for (int d = 0; d < 2; d++) begin
      chk($countones(~gnt_v[d]) <= 1, "R2 single grant", $countones(~gnt_v[d]), 1);
      chk(prev_g[d] == NONE || gnt_v[d] == NONE || gnt_v[d] == prev_g[d],
          "R3 dead cycle on handover", int'(gnt_v[d]), int'(prev_g[d]));
      prev_g[d] = gnt_v[d];
      g = low_bit(gnt_v[d]);
      if (busy[d] > 0) begin
        if (d == 0 && g >= 0 && g != owner[0]) hidden_seen = 1'b1;
        busy[d]--;
        if (busy[d] == 0) begin
          frame_n[d] = 1'b1;
          irdy_n[d]  = 1'b1;
        end
      end else if (frame_n[d] && g >= 0 && !req_v[g]) begin
        frame_n[d] = 1'b0;
        irdy_n[d]  = 1'b0;
        busy[d]    = blen;
        owner[d]   = g;
        if (log_n[d] < 64) log_m[d][log_n[d]] = g;
        log_n[d]++;
      end
    end
  endtask

  task automatic drain();
    int i;
    req_v = '1;
    for (i = 0; i < 500 && (busy[0] > 0 || busy[1] > 0); i++) step();
    chk(i < 500, "R6 bus drained", i, 500);
    repeat (4) step();
  endtask

  initial begin
    int n0, n1, exp, i;
    for (int d = 0; d < 2; d++) begin
      busy[d] = 0; owner[d] = -1; log_n[d] = 0; prev_g[d] = NONE;
    end
    repeat (3) @(negedge clk);
    chk(gnt_v[0] == NONE, "R1 grants high in reset", int'(gnt_v[0]), int'(NONE));
    chk(gnt_v[1] == NONE, "R1 grants high in reset (fixed)", int'(gnt_v[1]), int'(NONE));
    rst = 1'b0;
    chk(gnt_v[0] == NONE, "R1 no grant before first edge", int'(gnt_v[0]), int'(NONE));
    @(negedge clk);
    chk(gnt_v[0] == ~NM'(1), "R1 park after reset", int'(gnt_v[0]), int'(~NM'(1)));
    chk(gnt_v[1] == ~NM'(1), "R1 park after reset (fixed)", int'(gnt_v[1]), int'(~NM'(1)));
    prev_g[0] = gnt_v[0];
    prev_g[1] = gnt_v[1];

    // Full load: nested order (R4), fixed priority (R5), hidden handover (R8).
    blen  = 4;
    req_v = '0;
    for (i = 0; i < 2000 && (log_n[0] < 18 || log_n[1] < 4); i++) step();
    chk(i < 2000, "R4 full load progress", log_n[0], 18);
    for (int k = 0; k < 18; k++) begin
      exp = (k % (NH + 1) < NH) ? k % (NH + 1) : NH + ((k / (NH + 1)) % NL);
      chk(log_m[0][k] == exp, "R4 nested rotation order", log_m[0][k], exp);
    end
    for (int k = 0; k < 4; k++)
      chk(log_m[1][k] == 0, "R5 fixed priority winner", log_m[1][k], 0);
    chk(hidden_seen, "R8 grant moved during transfer", int'(hidden_seen), 1);

    drain();
    chk(gnt_v[0] == ~NM'(1), "R6 park on default", int'(gnt_v[0]), int'(~NM'(1)));

    // Only master 3 requests, then everyone stops (R6, R7).
    n0 = log_n[0];
    n1 = log_n[1];
    req_v = ~NM'(8);
    for (i = 0; i < 500 && (log_n[0] == n0 || log_n[1] == n1); i++) step();
    chk(i < 500, "R7 lone requester served", log_n[1] - n1, 1);
    chk(log_m[0][n0] == 3, "R4 lone low requester", log_m[0][n0], 3);
    chk(log_m[1][n1] == 3, "R7 lone low requester (fixed)", log_m[1][n1], 3);
    drain();
    chk(gnt_v[0] == ~NM'(1), "R6 default park after low owner", int'(gnt_v[0]), int'(~NM'(1)));
    chk(gnt_v[1] == ~NM'(8), "R7 park on last owner", int'(gnt_v[1]), int'(~NM'(8)));

    // Forfeit: master 1 withdraws while granted, before starting (R9).
    blen  = 8;
    n0    = log_n[0];
    req_v = ~NM'(7);
    for (i = 0; i < 500 && log_n[0] < n0 + 1; i++) step();
    chk(log_m[0][n0] == 0, "R9 first start", log_m[0][n0], 0);
    for (i = 0; i < 500 && gnt_v[0] != ~NM'(2); i++) step();
    chk(i < 500, "R9 master 1 granted", int'(gnt_v[0]), int'(~NM'(2)));
    req_v[1] = 1'b1;
    step();
    req_v[1] = 1'b0;
    for (i = 0; i < 500 && log_n[0] < n0 + 3; i++) step();
    chk(log_m[0][n0+1] == 2, "R9 turn skipped after drop", log_m[0][n0+1], 2);
    chk(log_m[0][n0+2] == 0, "R9 rotation resumes", log_m[0][n0+2], 0);
    drain();

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule